// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Vectoring

This block collects interrupt requests from the core (exceptions and software interrupts), from two external active-low pins and from on-chip peripherals. It ranks every pending request on a five-step priority scale. From lowest to highest the steps are: a software-only step below level 0, then maskable levels 0, 1 and 2, then a non-maskable level 3. The block selects one winner and compares its rank with the core's current priority mask. When the winner outranks the mask, or is non-maskable, the block raises a single registered interrupt request to the core. With that request it drives the winner's vector address, which is a programmable base plus a fixed per-source offset.

Software programs the block through a simple write port: the vector base, the sensitivity of each pin (level or edge) and a 2-bit priority code for every programmable source. Each external pin passes through a two-flop synchronizer. In level mode, a low pin requests service. In edge mode, a falling edge is latched, and the latch stays set until the core acknowledges that pin's source index.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, `core_irq` is 0, `vec_addr` is 0 and `irq_rank` is 0. The base is 0, every priority code is 0 (disabled) and both pins are in level mode.
- R2: Ranks are coded as 0 none, 1 LP, 2 level 0, 3 level 1, 4 level 2, 5 level 3. Core sources have fixed ranks: `core_req[3:0]` (source 0..3) is rank 5, bit 4 is rank 4, bit 5 is rank 3, bit 6 is rank 2 and bit 7 (software low-priority request) is rank 1.
- R3: A rank 5 request is forwarded whatever the value of `core_mask`.
- R4: Any other winner is forwarded only when its rank is strictly greater than `core_mask`, which uses the same rank coding.
- R5: The highest pending rank wins. Among equal ranks the lowest source index wins.
- R6: One cycle after the inputs, `vec_addr` equals base + 2 × source index and `irq_rank` equals the winner's rank. Both are 0 while `core_irq` is 0.
- R7: A write to address 0 loads the 16-bit base. Address 1, bit p selects edge mode for pin p. Address 2 holds 2-bit priority codes, where field k (bits 2k+1:2k) belongs to source 8+k. Pin 0 is source 8, pin 1 is source 9, and peripheral j is source 10+j. Code 1 selects level 0, code 2 level 1 and code 3 level 2.
- R8: A source whose priority code is 0 never produces a request.
- R9: In level mode a low pin requests service. `core_irq` follows a pin change on the third rising edge after it.
- R10: In edge mode a falling pin edge sets a latch. The request appears on the fourth rising edge after the fall and persists after the pin returns high.
- R11: An acknowledge (`ack_valid`) whose `ack_idx` equals the pin's source index clears that pin's edge latch. An acknowledge with any other index leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 8 | Core exception and software interrupt requests, active high |
| periph_req | input | N_SRC-10 | Peripheral requests, active high |
| irq_pin_n | input | 2 | External interrupt pins, active low, asynchronous |
| core_mask | input | 3 | Core's current priority mask in rank coding |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_idx | input | IDX_W | Source index being acknowledged |
| core_irq | output | 1 | Registered interrupt request to the core |
| vec_addr | output | VEC_W | Registered vector address of the winner |
| irq_rank | output | 3 | Registered rank of the forwarded request |

## Verification
The assertions assume that core and peripheral requests are held as levels for at least a cycle, and that `core_mask` changes only between clock edges. They also assume that an acknowledge names a single source index. The bench drives every input at the falling clock edge and keeps requests steady for the whole sampled window. It holds both pins high except in the pin scenarios, and it pulses `ack_valid` for exactly one cycle. Each check is sampled after the number of rising edges that the register stages on that path require.

// File: rtl/irqa_pkg.sv
// Shared rank coding and fixed rank table for the interrupt arbiter.
// Assumes ranks fit in 3 bits; 0 means "no request".
package irqa_pkg;
    typedef logic [2:0] rank_t;
    localparam rank_t RANK_NONE = 3'd0;
    localparam rank_t RANK_LP   = 3'd1;
    localparam rank_t RANK_L0   = 3'd2;
    localparam rank_t RANK_L1   = 3'd3;
    localparam rank_t RANK_L2   = 3'd4;
    localparam rank_t RANK_L3   = 3'd5;

    localparam int N_CORE   = 8;   // core request lines
    localparam int N_PIN    = 2;   // external pins
    localparam int PIN_BASE = 8;   // source index of pin 0
    localparam int PER_BASE = 10;  // source index of peripheral 0

    // Fixed rank of core source i (0..7)
    function automatic rank_t core_rank(input int i);
        if (i < 4)       return RANK_L3;
        else if (i == 4) return RANK_L2;
        else if (i == 5) return RANK_L1;
        else if (i == 6) return RANK_L0;
        else             return RANK_LP;
    endfunction

    // Translate a 2-bit programmed code into a rank (0 = disabled)
    function automatic rank_t code_rank(input logic [1:0] code);
        return (code == 2'd0) ? RANK_NONE : rank_t'(code) + 3'd1;
    endfunction
endpackage

// File: rtl/irqa_regs.sv
// Programming registers: vector base, pin modes and per-source priority codes.
// Assumes one write per cycle; writes to unmapped addresses are dropped.
module irqa_regs #(
    parameter int N_PROG = 8,
    parameter int ADDR_W = 4,
    parameter int VEC_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [15:0]            wr_data,
    output logic [VEC_W-1:0]       base_o,
    output logic [1:0]             edge_mode_o,
    output logic [N_PROG-1:0][1:0] prio_o
);
    localparam int FPW = 8; // priority fields per word

    logic [VEC_W-1:0] base_q;
    logic [1:0]       mode_q;
    logic [1:0]       prio_q [N_PROG];

    // Base and pin-mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(0)) base_q <= VEC_W'(wr_data);
            if (wr_addr == ADDR_W'(1)) mode_q <= wr_data[1:0];
        end
    end

    for (genvar k = 0; k < N_PROG; k++) begin : g_prio
        // Priority code of programmable source k
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[k] <= 2'd0;
            else if (wr_en && wr_addr == ADDR_W'(2 + k / FPW))
                prio_q[k] <= wr_data[2*(k%FPW) +: 2];
        end
        assign prio_o[k] = prio_q[k];
    end

    assign base_o      = base_q;
    assign edge_mode_o = mode_q;
endmodule

// File: rtl/irqa_pin.sv
// One external pin: two-flop synchronizer, level sampling or falling-edge latch.
// Assumes pin_n is asynchronous and active low; ack_hit is a one-cycle strobe.
module irqa_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic ack_hit,
    output logic active
);
    logic s1_q, s2_q, s3_q, pend_q;
    logic fall;

    // Synchronizer plus one delay stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= pin_n;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign fall = s3_q && !s2_q;

    // Edge latch: a new fall has precedence over an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n || !edge_mode) pend_q <= 1'b0;
        else if (fall)            pend_q <= 1'b1;
        else if (ack_hit)         pend_q <= 1'b0;
    end

    assign active = edge_mode ? pend_q : !s2_q;

    // R11
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && ack_hit && !fall) |=> !pend_q);
    // R10
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall) |=> pend_q);
    // R9
    lvl_nopend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> !pend_q);
endmodule

// File: rtl/irqa_pick.sv
// Combinational winner selection: highest rank, lowest index on a tie.
// Assumes rank 0 marks an idle source.
module irqa_pick
    import irqa_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int IDX_W = 4
) (
    input  logic [N_SRC-1:0][2:0] rank_i,
    output rank_t                 win_rank,
    output logic [IDX_W-1:0]      win_idx
);
    // Scan from the top index down so lower indices take ties
    always_comb begin
        win_rank = RANK_NONE;
        win_idx  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (rank_i[i] != RANK_NONE && rank_i[i] >= win_rank) begin
                win_rank = rank_i[i];
                win_idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
// Top: ranks all sources, picks a winner, masks it against the core level
// and registers the request, vector and rank. Assumes N_SRC >= 11.
module irq_prio_arbiter
    import irqa_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int ADDR_W = 4,
    parameter int VEC_W  = 16,
    parameter int STRIDE = 2,
    parameter int IDX_W  = $clog2(N_SRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            core_req,
    input  logic [N_SRC-11:0]     periph_req,
    input  logic [1:0]            irq_pin_n,
    input  logic [2:0]            core_mask,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [15:0]           wr_data,
    input  logic                  ack_valid,
    input  logic [IDX_W-1:0]      ack_idx,
    output logic                  core_irq,
    output logic [VEC_W-1:0]      vec_addr,
    output logic [2:0]            irq_rank
);
    localparam int N_PROG = N_SRC - PIN_BASE;

    logic [VEC_W-1:0]       base;
    logic [1:0]             edge_mode;
    logic [N_PROG-1:0][1:0] prio;
    logic [N_PIN-1:0]       pin_act;
    logic [N_SRC-1:0][2:0]  rank;
    rank_t                  win_rank;
    logic [IDX_W-1:0]       win_idx;
    logic                   fwd;
    logic                   live_q;

    irqa_regs #(.N_PROG(N_PROG), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .base_o(base), .edge_mode_o(edge_mode), .prio_o(prio)
    );

    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
        irqa_pin u_pin (
            .clk(clk), .rst_n(rst_n), .pin_n(irq_pin_n[p]),
            .edge_mode(edge_mode[p]),
            .ack_hit(ack_valid && ack_idx == IDX_W'(PIN_BASE + p)),
            .active(pin_act[p])
        );
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_rank
        if (i < N_CORE) begin : g_core
            assign rank[i] = core_req[i] ? core_rank(i) : RANK_NONE;
        end else if (i < PER_BASE) begin : g_pinr
            assign rank[i] = pin_act[i-PIN_BASE] ? code_rank(prio[i-PIN_BASE]) : RANK_NONE;
        end else begin : g_per
            assign rank[i] = periph_req[i-PER_BASE] ? code_rank(prio[i-PIN_BASE]) : RANK_NONE;
        end
    end

    irqa_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
        .rank_i(rank), .win_rank(win_rank), .win_idx(win_idx)
    );

    assign fwd = (win_rank != RANK_NONE) &&
                 (win_rank > core_mask || win_rank == RANK_L3);

    // Output stage: request, vector and rank of the forwarded winner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_irq <= 1'b0;
            vec_addr <= '0;
            irq_rank <= RANK_NONE;
        end else begin
            core_irq <= fwd;
            vec_addr <= fwd ? base + VEC_W'(win_idx) * VEC_W'(STRIDE) : '0;
            irq_rank <= fwd ? win_rank : RANK_NONE;
        end
    end

    // Marks cycles whose previous cycle was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R4
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && core_irq) |-> (irq_rank > $past(core_mask) || irq_rank == RANK_L3));
    // R3
    nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(|core_req[3:0])) |-> (core_irq && irq_rank == RANK_L3));
    // R6
    vec0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(core_req[0])) |-> vec_addr == $past(base));
    // R6
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_irq |-> (vec_addr == '0 && irq_rank == RANK_NONE));
endmodule

// File: tb/sim_irq_prio_arbiter.sv
module sim_irq_prio_arbiter;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  core_req = '0;
    logic [5:0]  periph_req = '0;
    logic [1:0]  irq_pin_n = 2'b11;
    logic [2:0]  core_mask = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_idx = '0;
    logic        core_irq;
    logic [15:0] vec_addr;
    logic [2:0]  irq_rank;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_prio_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .periph_req(periph_req),
        .irq_pin_n(irq_pin_n), .core_mask(core_mask), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ack_valid(ack_valid),
        .ack_idx(ack_idx), .core_irq(core_irq), .vec_addr(vec_addr),
        .irq_rank(irq_rank)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic e_irq,
                              input logic [15:0] e_vec, input logic [2:0] e_rank);
        n_chk++;
        if (core_irq !== e_irq || vec_addr !== e_vec || irq_rank !== e_rank) begin
            n_fail++;
            $display("FAIL %s: irq/vec/rank = %0b/%h/%0d, expected %0b/%h/%0d",
                     req, core_irq, vec_addr, irq_rank, e_irq, e_vec, e_rank);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        expect_out("R1 reset", 1'b0, 16'h0, 3'd0);
        periph_req = 6'h3F;   // all codes 0 after reset: nothing forwarded
        step(1);
        expect_out("R1 codes disabled", 1'b0, 16'h0, 3'd0);
        periph_req = '0;
        step(1);
    endtask

    task automatic t_nmi();
        wr(4'd0, 16'h0100);  // R7 base
        core_mask = 3'd5;
        core_req = 8'b0000_0100;
        step(1);
        expect_out("R3 nmi bypass", 1'b1, 16'h0104, 3'd5);
        core_req = 8'b0000_0101;
        step(1);
        expect_out("R5 tie lowest idx", 1'b1, 16'h0100, 3'd5);
        core_req = '0;
        step(1);
        expect_out("R6 idle vector zero", 1'b0, 16'h0, 3'd0);
    endtask

    task automatic t_mask();
        core_req = 8'b0001_0000;   // rank 4
        core_mask = 3'd4;
        step(1);
        expect_out("R4 equal to mask blocked", 1'b0, 16'h0, 3'd0);
        core_mask = 3'd3;
        step(1);
        expect_out("R4 above mask", 1'b1, 16'h0108, 3'd4);
        core_req = 8'b1000_0000;   // LP rank 1
        core_mask = 3'd0;
        step(1);
        expect_out("R2 LP source", 1'b1, 16'h010E, 3'd1);
        core_mask = 3'd1;
        step(1);
        expect_out("R4 LP masked", 1'b0, 16'h0, 3'd0);
        core_req = '0;
        core_mask = 3'd0;
        step(1);
    endtask

    task automatic t_periph();
        // R7 fields: src8=1, src9=2, src10=3, src11=3, src12=0
        wr(4'd2, 16'h00F9);
        periph_req = 6'b000011;
        step(1);
        expect_out("R7 periph code 3 tie", 1'b1, 16'h0114, 3'd4);
        periph_req = 6'b000010;
        step(1);
        expect_out("R5 single periph", 1'b1, 16'h0116, 3'd4);
        core_req = 8'b0001_0000;   // same rank, lower index
        step(1);
        expect_out("R5 core beats periph on tie", 1'b1, 16'h0108, 3'd4);
        core_req = 8'b0100_0000;   // rank 2 vs periph rank 4
        step(1);
        expect_out("R5 higher rank wins", 1'b1, 16'h0116, 3'd4);
        core_req = '0;
        periph_req = 6'b000100;    // source 12 disabled
        step(1);
        expect_out("R8 disabled source", 1'b0, 16'h0, 3'd0);
        periph_req = '0;
        step(1);
    endtask

    task automatic t_pin_level();
        irq_pin_n[0] = 1'b0;
        step(2);
        expect_out("R9 level latency not yet", 1'b0, 16'h0, 3'd0);
        step(1);
        expect_out("R9 level low active", 1'b1, 16'h0110, 3'd2);
        irq_pin_n[0] = 1'b1;
        step(3);
        expect_out("R9 level clears on high", 1'b0, 16'h0, 3'd0);
    endtask

    task automatic t_pin_edge();
        wr(4'd1, 16'h0002);        // pin 1 edge mode
        step(1);
        irq_pin_n[1] = 1'b0;
        step(1);
        irq_pin_n[1] = 1'b1;
        step(2);
        expect_out("R10 edge not yet", 1'b0, 16'h0, 3'd0);
        step(1);
        expect_out("R10 edge latched", 1'b1, 16'h0112, 3'd3);
        step(3);
        expect_out("R10 edge held after rise", 1'b1, 16'h0112, 3'd3);
        ack_valid = 1'b1; ack_idx = 4'd8;
        step(1);
        ack_valid = 1'b0;
        step(1);
        expect_out("R11 wrong ack no effect", 1'b1, 16'h0112, 3'd3);
        ack_valid = 1'b1; ack_idx = 4'd9;
        step(1);
        ack_valid = 1'b0;
        step(1);
        expect_out("R11 ack clears latch", 1'b0, 16'h0, 3'd0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_nmi();
        t_mask();
        t_periph();
        t_pin_level();
        t_pin_edge();
        done = 1'b1;
    end

    initial begin : watchdog
        int cyc;
        for (cyc = 0; cyc < 5000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule